// File: doc/BRIEF.md
# Load/Store Operand Sequencing Unit

This block is the controller and datapath of one load/store computation unit. An issue pulse hands it an operation descriptor: store or load, immediate or indexed addressing, an update flag, a 4-bit transfer length and a byte-order flag. The unit then requests only the register operands that this combination needs over separate request/grant read ports. It forms the effective address from the latched base plus either the latched immediate or a second operand, and offers that address to a memory port. It returns load data and, when update is set, the effective address over two register write ports.

Every request line stays high until its grant input is high for one cycle and drops on the next cycle. Operand data is taken only in the grant cycle. The effective-address writeback follows its own request/grant path, apart from the memory access. Busy falls once every required grant has been seen. The unit can then take the next issue.

Top module: `lsseq_top`

## Requirements
- R1: `busy` rises in the cycle after an edge at which `issueIn` was high while the unit was idle. An `issueIn` (with its descriptor and immediate) seen while `busy` is high is ignored.
- R2: Every request output (`rdReq[2:0]`, `wrReq[1:0]`, `adReq`, `stReq`) stays high from the cycle it rises until the cycle after its grant input was high, and it is low in that next cycle. A grant input while its request is low raises nothing and changes no state.
- R3: Index 0 of `rdReq` (base operand) is requested on every operation. Index 1 (second operand) is requested only when `opImm`=0. Index 2 (store data) is requested only when `opStore`=1.
- R4: An operand is latched only at an edge where its `rdGo` bit and its `rdReq` bit are both high. Values on `rdData0..2` at any other time have no effect.
- R5: The effective address is `rdData0 + (opImm ? immIn : rdData1)` truncated to ADDR_W bits. `memAddrStb` is high for exactly one cycle per operation: the first cycle in which both address operands are held.
- R6: `adReq` rises in the cycle after `memAddrStb`. `memAddrOk` rises in the cycle after `adGo` and stays high, with `memAddr` stable and equal to the effective address, until `busy` falls. Both return low together with `busy`.
- R7: A store raises `stReq` once `memAddrOk` is high and the store data has been latched, with the formatted store data on `memStData`. A store never raises `wrReq[0]`.
- R8: A load latches `memLdData` at the first edge where `memLdValid` and `memAddrOk` are both high. `memLdValid` earlier than that is ignored. `wrReq[0]` rises in the next cycle, with the formatted load data on `wrData0`. A load never raises `stReq`.
- R9: When `opUpdate`=1, `wrReq[1]` rises in the cycle after `adGo`, with the effective address (zero-extended) on `wrData1`, whatever the state of the memory access. When `opUpdate`=0, `wrReq[1]` never rises.
- R10: Data formatting uses n = min(`opLen`, DATA_W/8) bytes. Bytes at index n and above are zero. When `opRevBit`=0 the low n bytes are reversed (byte i takes input byte n-1-i). When `opRevBit`=1 they pass unchanged. This applies to `memStData` and to `wrData0`.
- R11: `busy` falls two cycles after the final required grant was driven: the edge that sees the grant clears the request, and the next edge clears `busy`. While idle, all requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueIn | input | 1 | Issue pulse |
| opStore | input | 1 | 1 = store, 0 = load |
| opImm | input | 1 | 1 = immediate addressing, 0 = indexed |
| opUpdate | input | 1 | Write the effective address back |
| opLen | input | 4 | Transfer length in bytes |
| opRevBit | input | 1 | 0 = byte-reverse, 1 = keep order |
| immIn | input | DATA_W | Immediate offset |
| rdReq | output | 3 | Read requests: base, second operand, store data |
| rdGo | input | 3 | Read grants |
| rdData0 | input | DATA_W | Base operand |
| rdData1 | input | DATA_W | Second operand |
| rdData2 | input | DATA_W | Store data operand |
| wrReq | output | 2 | Write requests: load result, effective address |
| wrGo | input | 2 | Write grants |
| wrData0 | output | DATA_W | Formatted load result |
| wrData1 | output | DATA_W | Effective address, zero-extended |
| adReq | output | 1 | Address request |
| adGo | input | 1 | Address grant |
| stReq | output | 1 | Store request |
| stGo | input | 1 | Store grant |
| memAddr | output | ADDR_W | Effective address to the memory port |
| memAddrOk | output | 1 | Held address-valid flag |
| memAddrStb | output | 1 | One-cycle address-valid pulse |
| memStData | output | DATA_W | Formatted store data |
| memLdValid | input | 1 | Load data valid from memory |
| memLdData | input | DATA_W | Load data from memory |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the unit with DATA_W=64 and ADDR_W=16. With eight bytes per word, every length code from 0 to 15 can be driven: the zero-length case, odd lengths, full words, and the codes above eight that clamp. The 16-bit address makes truncation of the random 64-bit sums part of every case. The sweep covers all eight store/load × addressing × update combinations. Each combination runs under both byte orders, seven lengths and grant delays of zero, one and three cycles. Operand and load buses carry inverted junk outside their grant cycles. A second issue is held into the busy period, and every grant is pulsed while the unit is idle.

// File: rtl/lsseq_pkg.sv
package lsseq_pkg;
  localparam int REQ_N  = 7;
  localparam int RQ_RD0 = 0;
  localparam int RQ_RD1 = 1;
  localparam int RQ_RD2 = 2;
  localparam int RQ_WR0 = 3;
  localparam int RQ_WR1 = 4;
  localparam int RQ_AD  = 5;
  localparam int RQ_ST  = 6;

  typedef struct packed {
    logic       capIssue;
    logic [2:0] capOp;
    logic       capLd;
  } strobe_t;
endpackage

// File: rtl/lsseq_reqbank.sv
module lsseq_reqbank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] setIn,
  input  logic [N-1:0] goIn,
  output logic [N-1:0] reqOut
);
  logic [N-1:0] reqQ;

  // One set/clear cell per request; the clear wins when both arrive together.
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN) reqQ[g] <= 1'b0;
      else       reqQ[g] <= (reqQ[g] | setIn[g]) & ~goIn[g];
    end

    p_fall_needs_go_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(reqQ[g]) |-> $past(goIn[g]));
    p_go_drops_req_r2: assert property (@(posedge clk) disable iff (!rstN)
      (reqQ[g] && goIn[g]) |=> !reqQ[g]);
  end

  assign reqOut = reqQ;
endmodule

// File: rtl/lsseq_ctrl.sv
module lsseq_ctrl
  import lsseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueIn,
  input  logic       opStore,
  input  logic       opImm,
  input  logic       opUpdate,
  input  logic [2:0] rdGo,
  input  logic [1:0] wrGo,
  input  logic       adGo,
  input  logic       stGo,
  input  logic       memLdValid,
  output logic [2:0] rdReq,
  output logic [1:0] wrReq,
  output logic       adReq,
  output logic       stReq,
  output logic       busy,
  output logic       memAddrOk,
  output logic       memAddrStb,
  output strobe_t    strobes
);
  logic [REQ_N-1:0] reqQ, reqSet, reqGo;
  logic busyQ, isStore, isImm, isUpd, aluValidQ, addrOkQ;
  logic stLaunched, ldGot, wr1Launched;
  logic accept, aluValid, addrStb, adGrant, stStart, ldCap, finish;

  assign reqGo    = {stGo, adGo, wrGo, rdGo};
  assign accept   = issueIn & ~busyQ;
  assign aluValid = busyQ & ~reqQ[RQ_RD0] & ~reqQ[RQ_RD1];
  assign addrStb  = aluValid & ~aluValidQ;
  assign adGrant  = adGo & reqQ[RQ_AD];
  assign stStart  = busyQ & isStore & addrOkQ & ~reqQ[RQ_RD2] & ~stLaunched;
  assign ldCap    = busyQ & ~isStore & addrOkQ & memLdValid & ~ldGot;
  assign finish   = busyQ & addrOkQ & (isStore ? stLaunched : ldGot)
                  & (~isUpd | wr1Launched) & ~(|reqQ);

  always_comb begin
    reqSet         = '0;
    reqSet[RQ_RD0] = accept;
    reqSet[RQ_RD1] = accept & ~opImm;
    reqSet[RQ_RD2] = accept & opStore;
    reqSet[RQ_WR0] = ldCap;
    reqSet[RQ_WR1] = adGrant & isUpd;
    reqSet[RQ_AD]  = addrStb;
    reqSet[RQ_ST]  = stStart;
  end

  lsseq_reqbank #(.N(REQ_N)) reqBank_i (
    .clk    (clk),
    .rstN   (rstN),
    .setIn  (reqSet),
    .goIn   (reqGo),
    .reqOut (reqQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ       <= 1'b0;
      isStore     <= 1'b0;
      isImm       <= 1'b0;
      isUpd       <= 1'b0;
      aluValidQ   <= 1'b0;
      addrOkQ     <= 1'b0;
      stLaunched  <= 1'b0;
      ldGot       <= 1'b0;
      wr1Launched <= 1'b0;
    end else begin
      aluValidQ <= aluValid;
      if (accept) begin
        busyQ       <= 1'b1;
        isStore     <= opStore;
        isImm       <= opImm;
        isUpd       <= opUpdate;
        addrOkQ     <= 1'b0;
        stLaunched  <= 1'b0;
        ldGot       <= 1'b0;
        wr1Launched <= 1'b0;
      end else if (finish) begin
        busyQ   <= 1'b0;
        addrOkQ <= 1'b0;
      end else begin
        if (adGrant)         addrOkQ     <= 1'b1;
        if (stStart)         stLaunched  <= 1'b1;
        if (ldCap)           ldGot       <= 1'b1;
        if (adGrant & isUpd) wr1Launched <= 1'b1;
      end
    end
  end

  assign strobes.capIssue = accept;
  assign strobes.capOp    = rdGo & reqQ[RQ_RD2:RQ_RD0];
  assign strobes.capLd    = ldCap;

  assign rdReq      = reqQ[RQ_RD2:RQ_RD0];
  assign wrReq      = reqQ[RQ_WR1:RQ_WR0];
  assign adReq      = reqQ[RQ_AD];
  assign stReq      = reqQ[RQ_ST];
  assign busy       = busyQ;
  assign memAddrOk  = addrOkQ;
  assign memAddrStb = addrStb;

  p_busy_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(issueIn));
  p_load_no_op3_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !isStore) |-> !reqQ[RQ_RD2]);
  p_imm_no_op2_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && isImm) |-> !reqQ[RQ_RD1]);
  p_stb_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    addrStb |=> !addrStb);
  p_store_no_wr0_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && isStore) |-> !reqQ[RQ_WR0]);
  p_load_no_st_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !isStore) |-> !reqQ[RQ_ST]);
  p_no_upd_no_wr1_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !isUpd) |-> !reqQ[RQ_WR1]);
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busyQ |-> (reqQ == '0));
endmodule

// File: rtl/lsseq_dpath.sv
module lsseq_dpath
  import lsseq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              opImm,
  input  logic [3:0]        opLen,
  input  logic              opRevBit,
  input  logic [DATA_W-1:0] immIn,
  input  logic [DATA_W-1:0] rdData0,
  input  logic [DATA_W-1:0] rdData1,
  input  logic [DATA_W-1:0] rdData2,
  input  logic [DATA_W-1:0] memLdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memStData,
  output logic [DATA_W-1:0] wrData0,
  output logic [DATA_W-1:0] wrData1
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] baseQ, indexQ, stDataQ, immQ, ldQ, sum;
  logic              immSel, keepOrder;
  logic [3:0]        lenQ;

  function automatic logic [DATA_W-1:0] fmtBytes(
    input logic [DATA_W-1:0] d, input logic [3:0] len, input logic keep);
    logic [DATA_W-1:0] r;
    int n;
    n = (int'(len) > NBYTES) ? NBYTES : int'(len);
    r = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < n) r[i*8 +: 8] = keep ? d[i*8 +: 8] : d[(n-1-i)*8 +: 8];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; indexQ <= '0; stDataQ <= '0; immQ <= '0; ldQ <= '0;
      immSel <= 1'b0; keepOrder <= 1'b0; lenQ <= '0;
    end else begin
      if (strobes.capIssue) begin
        immQ      <= immIn;
        immSel    <= opImm;
        lenQ      <= opLen;
        keepOrder <= opRevBit;
      end
      if (strobes.capOp[0]) baseQ   <= rdData0;
      if (strobes.capOp[1]) indexQ  <= rdData1;
      if (strobes.capOp[2]) stDataQ <= rdData2;
      if (strobes.capLd)    ldQ     <= fmtBytes(memLdData, lenQ, keepOrder);
    end
  end

  assign sum       = baseQ + (immSel ? immQ : indexQ);
  assign memAddr   = sum[ADDR_W-1:0];
  assign wrData1   = DATA_W'(memAddr);
  assign memStData = fmtBytes(stDataQ, lenQ, keepOrder);
  assign wrData0   = ldQ;
endmodule

// File: rtl/lsseq_top.sv
module lsseq_top
  import lsseq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueIn,
  input  logic              opStore,
  input  logic              opImm,
  input  logic              opUpdate,
  input  logic [3:0]        opLen,
  input  logic              opRevBit,
  input  logic [DATA_W-1:0] immIn,
  output logic [2:0]        rdReq,
  input  logic [2:0]        rdGo,
  input  logic [DATA_W-1:0] rdData0,
  input  logic [DATA_W-1:0] rdData1,
  input  logic [DATA_W-1:0] rdData2,
  output logic [1:0]        wrReq,
  input  logic [1:0]        wrGo,
  output logic [DATA_W-1:0] wrData0,
  output logic [DATA_W-1:0] wrData1,
  output logic              adReq,
  input  logic              adGo,
  output logic              stReq,
  input  logic              stGo,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memAddrOk,
  output logic              memAddrStb,
  output logic [DATA_W-1:0] memStData,
  input  logic              memLdValid,
  input  logic [DATA_W-1:0] memLdData,
  output logic              busy
);
  strobe_t strobes;

  lsseq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .issueIn(issueIn), .opStore(opStore),
    .opImm(opImm), .opUpdate(opUpdate), .rdGo(rdGo), .wrGo(wrGo),
    .adGo(adGo), .stGo(stGo), .memLdValid(memLdValid), .rdReq(rdReq),
    .wrReq(wrReq), .adReq(adReq), .stReq(stReq), .busy(busy),
    .memAddrOk(memAddrOk), .memAddrStb(memAddrStb), .strobes(strobes)
  );

  lsseq_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opImm(opImm),
    .opLen(opLen), .opRevBit(opRevBit), .immIn(immIn), .rdData0(rdData0),
    .rdData1(rdData1), .rdData2(rdData2), .memLdData(memLdData),
    .memAddr(memAddr), .memStData(memStData), .wrData0(wrData0),
    .wrData1(wrData1)
  );

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memAddrOk && $past(memAddrOk)) |-> $stable(memAddr));
  p_ok_needs_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    memAddrOk |-> busy);
endmodule

// File: tb/lsseq_top_tb_top.sv
module lsseq_top_tb_top;
  localparam int DW = 64;
  localparam int AW = 16;
  localparam int NB = DW / 8;

  logic clk = 1'b0, rstN = 1'b0;
  logic issueIn = 0, opStore = 0, opImm = 0, opUpdate = 0, opRevBit = 0;
  logic [3:0] opLen = '0;
  logic [DW-1:0] immIn = '0, rdData0 = '0, rdData1 = '0, rdData2 = '0, memLdData = '0;
  logic [2:0] rdGo = '0;
  logic [1:0] wrGo = '0;
  logic adGo = 0, stGo = 0, memLdValid = 0;
  logic [2:0] rdReq;
  logic [1:0] wrReq;
  logic adReq, stReq, busy, memAddrOk, memAddrStb;
  logic [DW-1:0] wrData0, wrData1, memStData;
  logic [AW-1:0] memAddr;

  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  lsseq_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .issueIn(issueIn), .opStore(opStore), .opImm(opImm),
    .opUpdate(opUpdate), .opLen(opLen), .opRevBit(opRevBit), .immIn(immIn),
    .rdReq(rdReq), .rdGo(rdGo), .rdData0(rdData0), .rdData1(rdData1),
    .rdData2(rdData2), .wrReq(wrReq), .wrGo(wrGo), .wrData0(wrData0),
    .wrData1(wrData1), .adReq(adReq), .adGo(adGo), .stReq(stReq), .stGo(stGo),
    .memAddr(memAddr), .memAddrOk(memAddrOk), .memAddrStb(memAddrStb),
    .memStData(memStData), .memLdValid(memLdValid), .memLdData(memLdData),
    .busy(busy)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R10 reference: scatter input byte k to position k or n-1-k.
  function automatic logic [DW-1:0] expFmt(input logic [DW-1:0] d,
                                           input logic [3:0] len, input bit keep);
    logic [DW-1:0] r;
    int n;
    r = '0;
    n = int'(len);
    if (n > NB) n = NB;
    for (int k = 0; k < n; k++) begin
      if (keep) r[k*8 +: 8] = d[k*8 +: 8];
      else      r[(n-1-k)*8 +: 8] = d[k*8 +: 8];
    end
    return r;
  endfunction

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic runOne(input bit st, input bit im, input bit up,
                        input logic [3:0] ln, input bit rv, input int dly);
    logic [DW-1:0] v0, v1, v2, vi, vl, sum;
    logic [AW-1:0] eaExp;
    logic [6:0] reqNow, reqPrev, goNow, goPrev, seen;
    int cnt[7];
    int protoErr, addrErr, stbCount, stbErr, ldErr, doneCyc, lastGo, ldCnt;
    bit okPrev, stbPrev, ldSent, ldPrev;
    string tag;
    v0 = {$urandom, $urandom}; v1 = {$urandom, $urandom};
    v2 = {$urandom, $urandom}; vi = {$urandom, $urandom};
    vl = {$urandom, $urandom};
    sum = v0 + (im ? vi : v1);
    eaExp = sum[AW-1:0];
    $sformat(tag, "st=%0d imm=%0d upd=%0d len=%0d rev=%0d dly=%0d", st, im, up, ln, rv, dly);

    opStore = st; opImm = im; opUpdate = up; opLen = ln; opRevBit = rv;
    immIn = vi; issueIn = 1'b1;
    stepEdge();
    check(busy == 1'b1, {"R1 busy after issue ", tag}, DW'(busy), 1);
    // R1: a second issue with a different descriptor while busy is ignored
    opStore = ~st; opImm = ~im; opUpdate = ~up; opLen = ~ln; opRevBit = ~rv; immIn = ~vi;

    reqPrev = '0; goPrev = '0; seen = '0;
    for (int b = 0; b < 7; b++) cnt[b] = 0;
    protoErr = 0; addrErr = 0; stbCount = 0; stbErr = 0; ldErr = 0;
    doneCyc = -1; lastGo = -10; ldCnt = 0;
    okPrev = 0; stbPrev = 0; ldSent = 0; ldPrev = 0;

    for (int cyc = 0; cyc < 200; cyc++) begin
      reqNow = {stReq, adReq, wrReq, rdReq};
      seen |= reqNow;
      for (int b = 0; b < 7; b++) begin
        if (reqPrev[b] && goPrev[b] && reqNow[b]) protoErr++;
        if (reqPrev[b] && !goPrev[b] && !reqNow[b]) protoErr++;
      end
      if (memAddrStb) stbCount++;
      if (stbPrev && !adReq) stbErr++;
      if (goPrev[5] && !memAddrOk) addrErr++;
      if (memAddrOk && memAddr != eaExp) addrErr++;
      if (okPrev && !memAddrOk && busy) addrErr++;
      if (ldPrev && !wrReq[0]) ldErr++;
      if (!busy) begin
        doneCyc = cyc;
        if (memAddrOk) addrErr++;
        break;
      end
      if (cyc == 1) issueIn = 1'b0;

      goNow = '0;
      for (int b = 0; b < 7; b++) begin
        if (reqNow[b]) begin
          cnt[b]++;
          if (cnt[b] > dly) begin goNow[b] = 1'b1; cnt[b] = 0; end
        end
      end
      if (|goNow) lastGo = cyc;
      // R4: operand buses carry junk except in their grant cycle
      rdData0 = goNow[0] ? v0 : ~v0;
      rdData1 = goNow[1] ? v1 : ~v1;
      rdData2 = goNow[2] ? v2 : ~v2;
      rdGo = goNow[2:0]; wrGo = goNow[4:3]; adGo = goNow[5]; stGo = goNow[6];
      if (goNow[6]) check(memStData == expFmt(v2, ln, rv), {"R7 R10 store data ", tag},
                          memStData, expFmt(v2, ln, rv));
      if (goNow[3]) check(wrData0 == expFmt(vl, ln, rv), {"R8 R10 load result ", tag},
                          wrData0, expFmt(vl, ln, rv));
      if (goNow[4]) check(wrData1 == DW'(eaExp), {"R9 address writeback ", tag},
                          wrData1, DW'(eaExp));
      // R8: early valid with junk before the address is accepted
      ldPrev = 0;
      if (!st && cyc == 0) begin
        memLdValid = 1'b1; memLdData = ~vl;
      end else if (!st && memAddrOk && !ldSent && ldCnt >= dly) begin
        memLdValid = 1'b1; memLdData = vl; ldSent = 1; ldPrev = 1;
      end else begin
        memLdValid = 1'b0; memLdData = ~vl;
      end
      if (memAddrOk) ldCnt++;
      reqPrev = reqNow; goPrev = goNow; okPrev = memAddrOk; stbPrev = memAddrStb;
      stepEdge();
    end
    rdGo = '0; wrGo = '0; adGo = 0; stGo = 0; memLdValid = 0; issueIn = 0;

    check(protoErr == 0, {"R2 request hold/drop ", tag}, DW'(protoErr), 0);
    check(seen[2:0] == {st, ~im, 1'b1}, {"R3 read requests ", tag},
          DW'(seen[2:0]), DW'({st, ~im, 1'b1}));
    check(stbCount == 1 && stbErr == 0, {"R5 address strobe ", tag}, DW'(stbCount), 1);
    check(addrErr == 0 && seen[5], {"R6 address and ok ", tag}, DW'(addrErr), 0);
    if (st) check(seen[3] == 0 && seen[6] == 1, {"R7 store requests ", tag},
                  DW'({seen[6], seen[3]}), 2'b10);
    else    check(seen[3] == 1 && seen[6] == 0 && ldErr == 0, {"R8 load requests ", tag},
                  DW'({seen[6], seen[3]}), 2'b01);
    check(seen[4] == up, {"R9 update request ", tag}, DW'(seen[4]), DW'(up));
    check(doneCyc == lastGo + 2, {"R11 release timing ", tag}, DW'(doneCyc), DW'(lastGo + 2));

    // R2: stray grants while idle raise nothing
    rdGo = '1; wrGo = '1; adGo = 1; stGo = 1; memLdValid = 1;
    stepEdge();
    rdGo = '0; wrGo = '0; adGo = 0; stGo = 0; memLdValid = 0;
    stepEdge();
    check({stReq, adReq, wrReq, rdReq, busy, memAddrOk} == '0, {"R2 idle grants ", tag},
          DW'({stReq, adReq, wrReq, rdReq, busy, memAddrOk}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [3:0] lens[7];
    int dlys[3];
    lens = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd8, 4'd12};
    dlys = '{0, 1, 3};
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    stepEdge();
    check(busy == 0, "R1 reset busy", DW'(busy), 0);
    check({stReq, adReq, wrReq, rdReq} == '0, "R2 reset requests",
          DW'({stReq, adReq, wrReq, rdReq}), 0);
    check(memAddrOk == 0 && memAddrStb == 0, "R6 reset address flags",
          DW'({memAddrOk, memAddrStb}), 0);
    for (int m = 0; m < 8; m++)
      for (int l = 0; l < 7; l++)
        for (int r = 0; r < 2; r++)
          for (int d = 0; d < 3; d++)
            runOne(m[2], m[1], m[0], lens[l], r[0], dlys[d]);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule